// File: doc/BRIEF.md
# PHY LED Source Selector

This block drives the two status LED outputs of an Ethernet PHY. A 16-bit configuration word has one 4-bit source code for each LED. A status bus brings in link up, receive and transmit activity, 100 Mb/s and 10 Mb/s speed, and full duplex. For each LED the block picks one of these according to its code and registers the result onto the pin.

Activity is usually a string of single-cycle pulses. A stretcher merges receive and transmit activity and holds it for a minimum on-time, so each burst stays visible. The stretcher is a two-state machine: IDLE, and HOLD with a down-counter. On activity it goes from IDLE to HOLD and loads the counter. A new pulse while in HOLD reloads the counter. HOLD returns to IDLE on the cycle the counter leaves 1 with no new pulse.

Each LED also has a link/blink machine used by code 0x8. Its states are DARK, STEADY, FLASH_ON and FLASH_OFF:
- Whenever code 0x8 is not selected, or link is down, the machine goes to DARK.
- With link up and no stretched activity, it goes to STEADY.
- When activity starts, DARK moves to FLASH_ON and STEADY moves to FLASH_OFF.
- FLASH_ON and FLASH_OFF swap each time a half-period counter expires.

Top module: `phy_led_sel`

## Requirements
- R1: Bits 15:8 of the configuration word always read as zero, and writes to them have no effect.
- R2: After reset the word reads 0x0010. LED1 (bits 7:4) holds code 0x1 and LED0 (bits 3:0) holds code 0x0. Both LEDs are off while status is idle.
- R3: Code 0x0 shows link up on the LED.
- R4: Code 0x1 shows receive-or-transmit activity. A single-cycle activity pulse keeps the LED on for exactly STRETCH_CYC cycles. A new pulse in the cycle the hold would end extends it to 2*STRETCH_CYC cycles.
- R5: Code 0x5 shows 100 Mb/s speed, code 0x6 shows 10 Mb/s speed and code 0x7 shows full duplex.
- R6: Codes 0x2, 0x3, 0x4 and 0x9 to 0xF keep the LED off whatever the status. They are stored and read back unchanged.
- R7: Code 0x8 lights the LED steadily while link is up with no stretched activity, and keeps it off while link is down.
- R8: Under code 0x8 with link up and continuing activity, the LED is off for BLINK_HALF cycles, then on for BLINK_HALF cycles, and so on. Link dropping takes priority over a due phase change.
- R9: Each LED output changes exactly one clock after a change of its status input or of its stored code.
- R10: A write stores bits 7:0 on the clock edge where the write enable is seen. The word holds between writes, and each LED follows only its own field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Configuration write enable |
| reg_wdata | input | 16 | Configuration write data |
| reg_rdata | output | 16 | Configuration read data |
| link_up | input | 1 | Link established |
| rx_activity | input | 1 | Receive activity pulse |
| tx_activity | input | 1 | Transmit activity pulse |
| speed_100 | input | 1 | 100 Mb/s mode |
| speed_10 | input | 1 | 10 Mb/s mode |
| full_duplex | input | 1 | Full-duplex mode |
| led_out | output | 2 | LED drives; bit 0 is LED0, bit 1 is LED1 |

## Verification
Two events can fall on the same clock here.

The first is the stretcher's hold running out in the same cycle a fresh activity pulse arrives. The bench times a second pulse to land exactly on the expiry cycle. It then counts the LED's on-cycles, which must form one unbroken run of twice the stretch length.

The second is a blink phase change falling in the same cycle as a link drop. The bench drops link on the cycle a FLASH_OFF to FLASH_ON change is due. The LED must stay dark rather than light for a phase.

// File: rtl/phy_led_pkg.sv
package phy_led_pkg;

    localparam int unsigned CODE_W = 4;

    localparam logic [CODE_W-1:0] CODE_LINK       = 4'h0;
    localparam logic [CODE_W-1:0] CODE_ACT        = 4'h1;
    localparam logic [CODE_W-1:0] CODE_SPD100     = 4'h5;
    localparam logic [CODE_W-1:0] CODE_SPD10      = 4'h6;
    localparam logic [CODE_W-1:0] CODE_FDX        = 4'h7;
    localparam logic [CODE_W-1:0] CODE_LINK_BLINK = 4'h8;

    typedef struct packed {
        logic link;
        logic act;
        logic spd100;
        logic spd10;
        logic fdx;
    } led_stat_t;

    typedef enum logic {
        ST_IDLE,
        ST_HOLD
    } str_state_e;

    typedef enum logic [1:0] {
        BL_DARK,
        BL_STEADY,
        BL_FLASH_ON,
        BL_FLASH_OFF
    } blink_state_e;

endpackage

// File: rtl/phy_led_cfg_reg.sv
module phy_led_cfg_reg #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned SEL_W  = 4,
    parameter int unsigned N_LED  = 2,
    parameter logic [SEL_W*N_LED-1:0] RST_VAL = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    output logic [N_LED-1:0][SEL_W-1:0] sel
);

    localparam int unsigned CFG_W = SEL_W * N_LED;

    logic [CFG_W-1:0] cfg_q;
    logic             unused_wr_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= RST_VAL;
        end else if (we) begin
            cfg_q <= wdata[CFG_W-1:0];
        end
    end

    assign unused_wr_hi = ^wdata[DATA_W-1:CFG_W];
    assign rdata        = {{(DATA_W-CFG_W){1'b0}}, cfg_q};

    for (genvar g = 0; g < N_LED; g++) begin : g_sel
        assign sel[g] = cfg_q[g*SEL_W +: SEL_W];
    end

    AST_WR_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rdata[CFG_W-1:0] == $past(wdata[CFG_W-1:0]))); // R10
    AST_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(rdata)); // R10

endmodule

// File: rtl/phy_led_act_stretch.sv
module phy_led_act_stretch
    import phy_led_pkg::*;
#(
    parameter int unsigned STRETCH_CYC = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_in,
    output logic act_vis
);

    localparam int unsigned CNT_W = (STRETCH_CYC > 2) ? $clog2(STRETCH_CYC) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(STRETCH_CYC - 1);

    str_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (act_in) begin
                    state_d = ST_HOLD;
                    cnt_d   = RELOAD;
                end
            end
            ST_HOLD: begin
                if (act_in) begin
                    cnt_d = RELOAD;
                end else if (cnt_q == CNT_W'(1)) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        act_vis = act_in || (state_q == ST_HOLD);
    end

    AST_STRETCH_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        act_in |=> act_vis); // R4
    AST_HOLD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (cnt_q != '0)); // R4

endmodule

// File: rtl/phy_led_channel.sv
module phy_led_channel
    import phy_led_pkg::*;
#(
    parameter int unsigned SEL_W      = 4,
    parameter int unsigned BLINK_HALF = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  led_stat_t        stat,
    output logic             led
);

    localparam int unsigned HC_W = $clog2(BLINK_HALF + 1);
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(BLINK_HALF - 1);

    blink_state_e    bl_q, bl_d;
    logic [HC_W-1:0] hcnt_q, hcnt_d;
    logic            tick;
    logic            flashing;
    logic            led_d;
    logic            rsvd_code;

    assign tick     = (hcnt_q == HC_LAST);
    assign flashing = (bl_q == BL_FLASH_ON) || (bl_q == BL_FLASH_OFF);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bl_q   <= BL_DARK;
            hcnt_q <= '0;
        end else begin
            bl_q   <= bl_d;
            hcnt_q <= hcnt_d;
        end
    end

    always_comb begin
        bl_d = bl_q;
        if ((sel != SEL_W'(CODE_LINK_BLINK)) || !stat.link) begin
            bl_d = BL_DARK;
        end else if (!stat.act) begin
            bl_d = BL_STEADY;
        end else begin
            unique case (bl_q)
                BL_DARK:      bl_d = BL_FLASH_ON;
                BL_STEADY:    bl_d = BL_FLASH_OFF;
                BL_FLASH_ON:  bl_d = tick ? BL_FLASH_OFF : BL_FLASH_ON;
                BL_FLASH_OFF: bl_d = tick ? BL_FLASH_ON : BL_FLASH_OFF;
                default:      bl_d = BL_DARK;
            endcase
        end
    end

    always_comb begin
        if (bl_d != bl_q) begin
            hcnt_d = '0;
        end else if (flashing) begin
            hcnt_d = hcnt_q + HC_W'(1);
        end else begin
            hcnt_d = '0;
        end
    end

    always_comb begin
        case (sel)
            SEL_W'(CODE_LINK):       led_d = stat.link;
            SEL_W'(CODE_ACT):        led_d = stat.act;
            SEL_W'(CODE_SPD100):     led_d = stat.spd100;
            SEL_W'(CODE_SPD10):      led_d = stat.spd10;
            SEL_W'(CODE_FDX):        led_d = stat.fdx;
            SEL_W'(CODE_LINK_BLINK): led_d = (bl_d == BL_STEADY) || (bl_d == BL_FLASH_ON);
            default:                 led_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            led <= 1'b0;
        end else begin
            led <= led_d;
        end
    end

    assign rsvd_code = ((sel >= SEL_W'(2)) && (sel <= SEL_W'(4))) || (sel > SEL_W'(8));

    AST_RSVD_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd_code |=> !led); // R6
    AST_LINK_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_W'(0)) |=> (led == $past(stat.link))); // R3
    AST_LB_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel == SEL_W'(8)) && !stat.link) |=> !led); // R7
    AST_LB_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel == SEL_W'(8)) && stat.link && !stat.act) |=> led); // R7
    AST_FLASH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel == SEL_W'(8)) && stat.link && stat.act && flashing && !tick) |=> $stable(led)); // R8

endmodule

// File: rtl/phy_led_sel.sv
module phy_led_sel
    import phy_led_pkg::*;
#(
    parameter int unsigned STRETCH_CYC = 4096,
    parameter int unsigned BLINK_HALF  = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        link_up,
    input  logic        rx_activity,
    input  logic        tx_activity,
    input  logic        speed_100,
    input  logic        speed_10,
    input  logic        full_duplex,
    output logic [1:0]  led_out
);

    localparam int unsigned N_LED  = 2;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned SEL_W  = CODE_W;
    localparam logic [SEL_W*N_LED-1:0] CFG_RST = {CODE_ACT, CODE_LINK};

    logic [N_LED-1:0][SEL_W-1:0] sel;
    logic                        act_vis;
    led_stat_t                   stat;

    phy_led_cfg_reg #(
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W),
        .N_LED  (N_LED),
        .RST_VAL(CFG_RST)
    ) u_cfg (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (reg_we),
        .wdata(reg_wdata),
        .rdata(reg_rdata),
        .sel  (sel)
    );

    phy_led_act_stretch #(
        .STRETCH_CYC(STRETCH_CYC)
    ) u_stretch (
        .clk    (clk),
        .rst_n  (rst_n),
        .act_in (rx_activity || tx_activity),
        .act_vis(act_vis)
    );

    always_comb begin
        stat.link   = link_up;
        stat.act    = act_vis;
        stat.spd100 = speed_100;
        stat.spd10  = speed_10;
        stat.fdx    = full_duplex;
    end

    for (genvar g = 0; g < N_LED; g++) begin : g_led
        phy_led_channel #(
            .SEL_W     (SEL_W),
            .BLINK_HALF(BLINK_HALF)
        ) u_ch (
            .clk  (clk),
            .rst_n(rst_n),
            .sel  (sel[g]),
            .stat (stat),
            .led  (led_out[g])
        );
    end

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> (reg_rdata[15:8] == 8'h00)); // R1

endmodule

// File: tb/phy_led_sel_tb.sv
`timescale 1ns/1ps
module phy_led_sel_tb_top;

    localparam int S = 8;
    localparam int H = 4;
    localparam int NV = 13;

    // [23:8] word, [7:2] {link,rx,tx,spd100,spd10,fdx}, [1:0] {led1,led0}
    localparam logic [23:0] VEC [NV] = '{
        {16'h0010, 6'b100000, 2'b01},
        {16'h0010, 6'b010000, 2'b10},
        {16'h0010, 6'b001000, 2'b10},
        {16'h0056, 6'b000100, 2'b10},
        {16'h0056, 6'b000010, 2'b01},
        {16'h0077, 6'b000001, 2'b11},
        {16'h0075, 6'b000100, 2'b01},
        {16'h0002, 6'b111111, 2'b10},
        {16'h0048, 6'b100000, 2'b01},
        {16'h0080, 6'b000000, 2'b00},
        {16'h00F9, 6'b111111, 2'b00},
        {16'h0081, 6'b100000, 2'b10},
        {16'h0018, 6'b011000, 2'b10}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        link_up = 1'b0, rx_activity = 1'b0, tx_activity = 1'b0;
    logic        speed_100 = 1'b0, speed_10 = 1'b0, full_duplex = 1'b0;
    logic [1:0]  led_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    phy_led_sel #(.STRETCH_CYC(S), .BLINK_HALF(H)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .link_up(link_up), .rx_activity(rx_activity),
        .tx_activity(tx_activity), .speed_100(speed_100), .speed_10(speed_10),
        .full_duplex(full_duplex), .led_out(led_out)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_st(input logic [5:0] s);
        {link_up, rx_activity, tx_activity, speed_100, speed_10, full_duplex} = s;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(3);
        // R2 reset state
        chk("R2 reset word", reg_rdata, 16'h0010);
        chk("R2 reset leds", {14'h0, led_out}, 16'h0000);

        // table walk: R3 R5 R6 R7 R10
        for (int v = 0; v < NV; v++) begin
            wr(VEC[v][23:8]);
            set_st(VEC[v][7:2]);
            idle(S + 4);
            chk("R10 readback", reg_rdata, VEC[v][23:8]);
            chk("R3/R5/R6/R7 table leds", {14'h0, led_out}, {14'h0, VEC[v][1:0]});
        end
        set_st(6'b000000);

        // R1 reserved bits ignore writes
        wr(16'hFFFF);
        chk("R1 reserved read zero", reg_rdata, 16'h00FF);
        wr(16'hA5C3);
        chk("R1 upper byte dropped", reg_rdata, 16'h00C3);
        // R6 reserved codes store unchanged
        wr(16'h0093);
        set_st(6'b111111);
        idle(S + 4);
        chk("R6 stored code", reg_rdata, 16'h0093);
        chk("R6 leds dark", {14'h0, led_out}, 16'h0000);
        set_st(6'b000000);

        // R9 latency on status change
        wr(16'h0010);
        idle(S + 4);
        link_up = 1'b1;
        #1;
        chk("R9 no early change", {15'h0, led_out[0]}, 16'h0000);
        @(negedge clk);
        chk("R9 one clock later", {15'h0, led_out[0]}, 16'h0001);
        // R9 latency on code change (LED0 -> code 6, speed_10 low)
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = 16'h0016;
        @(negedge clk);
        reg_we = 1'b0;
        chk("R9 old code still shown", {15'h0, led_out[0]}, 16'h0001);
        @(negedge clk);
        chk("R9 new code shown", {15'h0, led_out[0]}, 16'h0000);
        link_up = 1'b0;

        // R4 single pulse on LED1 (code 1)
        wr(16'h0010);
        idle(S + 4);
        begin
            int run = 0;
            rx_activity = 1'b1;
            for (int k = 1; k <= S + 2; k++) begin
                @(negedge clk);
                if (k == 1) rx_activity = 1'b0;
                if (led_out[1]) run++;
            end
            chk("R4 stretch length", 16'(run), 16'(S));
        end

        // R4 retrigger on expiry cycle (collision)
        idle(S + 4);
        begin
            int run = 0;
            rx_activity = 1'b1;
            for (int k = 1; k <= 2 * S + 1; k++) begin
                @(negedge clk);
                if (led_out[1] && run == k - 1) run++;
                rx_activity = (k == S);
            end
            chk("R4 retrigger run", 16'(run), 16'(2 * S));
            chk("R4 retrigger ends", {15'h0, led_out[1]}, 16'h0000);
        end

        // R7 / R8 code 8 on LED0
        wr(16'h0008);
        link_up = 1'b1;
        idle(S + 4);
        chk("R7 steady on", {15'h0, led_out[0]}, 16'h0001);
        tx_activity = 1'b1;
        for (int i = 1; i <= 4 * H; i++) begin
            @(negedge clk);
            chk("R8 blink phase", {15'h0, led_out[0]}, {15'h0, 1'(((i - 1) / H) % 2)});
        end
        tx_activity = 1'b0;
        idle(S + 4);
        chk("R7 steady after activity", {15'h0, led_out[0]}, 16'h0001);
        link_up = 1'b0;
        @(negedge clk);
        chk("R7 link down dark", {15'h0, led_out[0]}, 16'h0000);

        // R8 link drop on the toggle cycle (collision)
        link_up = 1'b1;
        idle(S + 4);
        tx_activity = 1'b1;
        idle(H);
        chk("R8 off phase", {15'h0, led_out[0]}, 16'h0000);
        link_up = 1'b0;
        @(negedge clk);
        chk("R8 link drop beats toggle", {15'h0, led_out[0]}, 16'h0000);
        @(negedge clk);
        chk("R8 stays dark", {15'h0, led_out[0]}, 16'h0000);
        tx_activity = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule